// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline. For each of the two ALU source operands it picks one of three values. The first is the register-file value that was latched with the instruction when it entered execute. The second is the ALU result of the instruction one stage ahead, in the memory stage. The third is the result of the instruction two stages ahead, in the writeback stage. With this choice, a dependent instruction can use a result that has not yet been written to the register file, and the pipeline does not stall.

The choice depends only on register numbers and write-enable flags. Each bypass source is considered only if it is going to write a register and its destination is not register zero, which always reads as zero. If both later stages target the same source register, the memory-stage result wins because it is the younger result. The block contains the two operand multiplexers, so it delivers the final operand values as well as the raw select codes. It is purely combinational and has no clock or state.

Top module: `fwd_unit`

## Requirements
- R1: When `exm_we_i` is 1, `exm_rd_i` is nonzero and `exm_rd_i` equals `rs_i`, `sel_a_o` is 2'b01.
- R2: When `exm_we_i` is 1, `exm_rd_i` is nonzero and `exm_rd_i` equals `rt_i`, `sel_b_o` is 2'b01.
- R3: When `mwb_we_i` is 1, `mwb_rd_i` is nonzero, `mwb_rd_i` equals an operand's source register and the memory stage does not qualify for that operand, that operand's select is 2'b10.
- R4: When both stages qualify for the same source register, the select is 2'b01, so the memory-stage value is used.
- R5: A destination of register 0 never produces a bypass, even when its write flag is set and the source register is also 0.
- R6: A stage whose write flag is 0 never produces a bypass, even when its destination matches.
- R7: When neither stage qualifies, the select is 2'b00 and the operand output equals the register-file value (`rf_a_i` or `rf_b_i`).
- R8: The operand outputs follow the select: 2'b01 gives `exm_res_i` and 2'b10 gives `mwb_res_i`. The select is never 2'b11, and the multiplexer would treat 2'b11 as 2'b00.
- R9: The selects for operands A and B are derived independently, so in the same cycle they may name different stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 5 | First source register number of the execute-stage instruction |
| rt_i | input | 5 | Second source register number of the execute-stage instruction |
| exm_rd_i | input | 5 | Destination register number in the memory stage |
| exm_we_i | input | 1 | Memory-stage instruction writes a register |
| mwb_rd_i | input | 5 | Destination register number in the writeback stage |
| mwb_we_i | input | 1 | Writeback-stage instruction writes a register |
| rf_a_i | input | 32 | Register-file value latched for operand A |
| rf_b_i | input | 32 | Register-file value latched for operand B |
| exm_res_i | input | 32 | ALU result held in the memory stage |
| mwb_res_i | input | 32 | Result value held in the writeback stage |
| sel_a_o | output | 2 | Source select for operand A |
| sel_b_o | output | 2 | Source select for operand B |
| op_a_o | output | 32 | Selected operand A value |
| op_b_o | output | 32 | Selected operand B value |

## Verification
The block has no state, so any fault in it appears in the same cycle as the inputs that trigger it. That fault is either a wrong select code or an operand value taken from the wrong stage. The stimulus draws register numbers from a small range, including register zero, so that matches, double matches and zero-destination cases happen often. The write flags and data values are random. Directed cases cover back-to-back writes to one register, which is where a priority fault would deliver an older value, and writes to register zero with the write flag set.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXM = 2'b01,
    FWD_MWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// One bypass source qualifies for one source register.
module fwd_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] dst_i,
  input  logic          we_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  logic dst_nz;
  assign dst_nz = |dst_i;
  assign hit_o  = we_i & dst_nz & (dst_i == src_i);
endmodule

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  output fwd_sel_e      sel_o
);
  logic exm_hit, mwb_hit;

  fwd_match #(.AW(AW)) u_exm (
    .dst_i(exm_rd_i), .we_i(exm_we_i), .src_i(src_i), .hit_o(exm_hit)
  );
  fwd_match #(.AW(AW)) u_mwb (
    .dst_i(mwb_rd_i), .we_i(mwb_we_i), .src_i(src_i), .hit_o(mwb_hit)
  );

  // younger stage wins
  always_comb begin
    if (exm_hit)      sel_o = FWD_EXM;
    else if (mwb_hit) sel_o = FWD_MWB;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fwd_sel_e      sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] exm_i,
  input  logic [DW-1:0] mwb_i,
  output logic [DW-1:0] op_o
);
  always_comb begin
    unique case (sel_i)
      FWD_EXM: op_o = exm_i;
      FWD_MWB: op_o = mwb_i;
      default: op_o = rf_i; // 11 falls back to register file
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] rt_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  input  logic [DW-1:0] rf_a_i,
  input  logic [DW-1:0] rf_b_i,
  input  logic [DW-1:0] exm_res_i,
  input  logic [DW-1:0] mwb_res_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [DW-1:0] op_a_o,
  output logic [DW-1:0] op_b_o
);
  localparam int unsigned NOPS = 2;

  logic [NOPS-1:0][AW-1:0] src;
  logic [NOPS-1:0][DW-1:0] rf_val;
  logic [NOPS-1:0][DW-1:0] op_val;
  fwd_sel_e                sel [NOPS];

  assign src[0]    = rs_i;
  assign src[1]    = rt_i;
  assign rf_val[0] = rf_a_i;
  assign rf_val[1] = rf_b_i;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_sel_unit #(.AW(AW)) u_sel (
      .src_i   (src[k]),
      .exm_rd_i(exm_rd_i),
      .exm_we_i(exm_we_i),
      .mwb_rd_i(mwb_rd_i),
      .mwb_we_i(mwb_we_i),
      .sel_o   (sel[k])
    );
    fwd_operand_mux #(.DW(DW)) u_mux (
      .sel_i(sel[k]),
      .rf_i (rf_val[k]),
      .exm_i(exm_res_i),
      .mwb_i(mwb_res_i),
      .op_o (op_val[k])
    );
  end

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
  assign op_a_o  = op_val[0];
  assign op_b_o  = op_val[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic [AW-1:0] rs_i,
  input logic [AW-1:0] rt_i,
  input logic [AW-1:0] exm_rd_i,
  input logic          exm_we_i,
  input logic [AW-1:0] mwb_rd_i,
  input logic          mwb_we_i,
  input logic [DW-1:0] rf_a_i,
  input logic [DW-1:0] rf_b_i,
  input logic [DW-1:0] exm_res_i,
  input logic [DW-1:0] mwb_res_i,
  input logic [1:0]    sel_a_o,
  input logic [1:0]    sel_b_o,
  input logic [DW-1:0] op_a_o,
  input logic [DW-1:0] op_b_o
);
  always_comb begin
    AST_EXM_A: assert (!(exm_we_i && exm_rd_i != '0 && exm_rd_i == rs_i) || sel_a_o == 2'b01); // R1
    AST_EXM_B: assert (!(exm_we_i && exm_rd_i != '0 && exm_rd_i == rt_i) || sel_b_o == 2'b01); // R2
    AST_MWB_A: assert (sel_a_o != 2'b10 || (mwb_we_i && mwb_rd_i == rs_i)); // R3
    AST_MWB_B: assert (sel_b_o != 2'b10 || (mwb_we_i && mwb_rd_i == rt_i)); // R3
    AST_NO_ZERO_A: assert (sel_a_o == 2'b00 || rs_i != '0); // R5
    AST_NO_ZERO_B: assert (sel_b_o == 2'b00 || rt_i != '0); // R5
    AST_WE_GATE: assert ((exm_we_i || (sel_a_o != 2'b01 && sel_b_o != 2'b01)) &&
                         (mwb_we_i || (sel_a_o != 2'b10 && sel_b_o != 2'b10))); // R6
    AST_NO_11: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11); // R8
    AST_DATA_A: assert (op_a_o == (sel_a_o == 2'b01 ? exm_res_i :
                                   sel_a_o == 2'b10 ? mwb_res_i : rf_a_i)); // R8
    AST_DATA_B: assert (op_b_o == (sel_b_o == 2'b01 ? exm_res_i :
                                   sel_b_o == 2'b10 ? mwb_res_i : rf_b_i)); // R8
  end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  logic        clk = 1'b0;
  logic [4:0]  rs, rt, exm_rd, mwb_rd;
  logic        exm_we, mwb_we;
  logic [31:0] rf_a, rf_b, exm_res, mwb_res;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fwd_unit u_dut (
    .rs_i(rs), .rt_i(rt), .exm_rd_i(exm_rd), .exm_we_i(exm_we),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .exm_res_i(exm_res), .mwb_res_i(mwb_res),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .op_a_o(op_a), .op_b_o(op_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] s);
    if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b01;
    if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
    return s == 2'b01 ? exm_res : (s == 2'b10 ? mwb_res : rf);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] a, input logic [4:0] b, input logic [4:0] xd,
                       input logic xw, input logic [4:0] wd, input logic ww);
    @(negedge clk);
    rs = a; rt = b; exm_rd = xd; exm_we = xw; mwb_rd = wd; mwb_we = ww;
    rf_a = $urandom; rf_b = $urandom; exm_res = $urandom; mwb_res = $urandom;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    ea = exp_sel(rs);
    eb = exp_sel(rt);
    chk({tag, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    chk({tag, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    chk({tag, " op_a R8"}, op_a, exp_op(ea, rf_a));
    chk({tag, " op_b R8"}, op_b, exp_op(eb, rf_b));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    apply(0, 0, 0, 0, 0, 0);
    chk("R7 idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R7 idle op_a", op_a, rf_a);
    chk("R7 idle op_b", op_b, rf_b);
    apply(7, 3, 7, 1, 0, 0);  chk("R1 exm A", {30'd0, sel_a}, 32'd1);
    chk("R1 exm A data", op_a, exm_res);
    apply(4, 9, 9, 1, 0, 0);  chk("R2 exm B", {30'd0, sel_b}, 32'd1);
    apply(6, 6, 0, 0, 6, 1);  chk("R3 mwb A", {30'd0, sel_a}, 32'd2);
    chk("R3 mwb B data", op_b, mwb_res);
    apply(5, 5, 5, 1, 5, 1);  chk("R4 both A", {30'd0, sel_a}, 32'd1);
    chk("R4 both B data", op_b, exm_res);
    apply(0, 0, 0, 1, 0, 1);  chk("R5 zero A", {30'd0, sel_a}, 32'd0);
    chk("R5 zero B data", op_b, rf_b);
    apply(8, 8, 8, 0, 8, 0);  chk("R6 no we A", {30'd0, sel_a}, 32'd0);
    apply(8, 8, 8, 0, 8, 1);  chk("R6 exm off, mwb on", {30'd0, sel_a}, 32'd2);
    apply(2, 11, 2, 1, 11, 1);
    chk("R9 A exm", {30'd0, sel_a}, 32'd1);
    chk("R9 B mwb", {30'd0, sel_b}, 32'd2);
    chk("R9 A data", op_a, exm_res);
    chk("R9 B data", op_b, mwb_res);
    for (int i = 0; i < 2000; i++) begin
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom));
      check_all("rand R1 R2 R3 R4 R5 R6 R7 R9");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule